// File: doc/BRIEF.md
# Multiplexed Peripheral Bus Controller

This block connects an on-chip request port to an external bus that serves flash parts and memory-mapped peripherals. The external bus is narrow and shares its sixteen lines between address and data. Each access starts with an address phase of one clock. In that clock a latch strobe tells external latches to capture the address. Data phases of a fixed length follow, one for each transfer. A recovery clock with every chip enable off closes the access.

Three low address pins are not shared with data. During a burst read they step through the bytes or half-words. Which of these pins step depends on the bus width, which is chosen at run time as 8 or 16 bits. On reads the block assembles the narrow transfers into one wide internal word. On writes it splits the internal word into narrow transfers, each with its own address phase, because bursts are not allowed on writes. Two windows, each with a programmable base and size, each drive their own chip enable. An address outside both windows gets an error response and causes no bus activity.

Top module: `pbus_mux_ctrl`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, and `pb_ale`, `pb_ce`, `pb_rd`, `pb_wr` and `rsp_valid` are all 0.
- R2: An accepted request is followed in the next clock by an address phase. It lasts exactly one clock, with `pb_ale`=1, `pb_a_hi`=address[22:16], `pb_ad_o`=address[15:0] and `pb_ad_oe`=1. `pb_ale` is 0 at every other time.
- R3: Outside the address phase the shared lines carry only data. During read data phases `pb_ad_oe`=0. During write data phases `pb_ad_oe`=1 and the lines carry write data.
- R4: Each transfer lasts `DATA_CYC` clocks with `pb_rd` (read) or `pb_wr` (write) high. Read data is sampled on the last clock of the transfer.
- R5: With `cfg_bus16`=1, a read with `req_len`=L makes L+1 transfers after one address phase. `pb_a_lo[2:1]` starts at address[2:1] and increases by one each transfer, modulo 4. `pb_a_lo[0]`=0. Transfer i fills `rsp_rdata[16i+15:16i]`.
- R6: With `cfg_bus16`=0, a burst read steps `pb_a_lo[1:0]` from address[1:0], modulo 4, and holds `pb_a_lo[2]`=address[2]. Transfer i fills `rsp_rdata[8i+7:8i]` from `pb_ad_i[7:0]`. All bits of `rsp_rdata` that no transfer fills are 0.
- R7: A read with `req_len`=0 makes one transfer at a single location and then ends.
- R8: Window k is hit when base_k <= address < base_k + size_k. Base and size are field k of `cfg_win_base` and `cfg_win_size`, each `ADDR_W` bits wide. Only the hit window's `pb_ce` bit is high, and it is high during the address and data phases. When both windows hit, window 0 wins.
- R9: An address that hits no window gives `rsp_valid`=1 and `rsp_err`=1 in the clock after acceptance. No address phase and no chip enable occur.
- R10: A write with `req_len`=L>0 becomes L+1 single transfers. Transfer x uses address + x·w, where w is 2 bytes in 16-bit mode and 1 byte in 8-bit mode. Its data is lane x of `req_wdata`: bits [16x+15:16x] in 16-bit mode, or bits [8x+7:8x] on `pb_ad_o[7:0]` in 8-bit mode. Its `pb_be` is lane x of `req_be`. With `WRITE_SPLIT`=0 such a write is instead rejected like R9.
- R11: Every transfer group ends with one recovery clock in which `pb_ce`=0, `pb_rd`=0 and `pb_wr`=0. In the recovery clock of the last group, `rsp_valid`=1 and `rsp_err`=0.
- R12: `req_ready` is 0 from the clock after acceptance through the response clock, and 1 again in the clock after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bus16 | input | 1 | 1 selects the 16-bit bus, 0 the 8-bit bus |
| cfg_win_base | input | NUM_WIN*ADDR_W | Window base addresses, window k in field k |
| cfg_win_size | input | NUM_WIN*ADDR_W | Window sizes in bytes, window k in field k |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_len | input | 2 | Transfer count minus one |
| req_wdata | input | 64 | Write data, one lane per transfer |
| req_be | input | 8 | Byte enables matching `req_wdata` |
| rsp_valid | output | 1 | Response strobe, one clock |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 64 | Assembled read data |
| pb_ale | output | 1 | Address latch strobe |
| pb_ce | output | NUM_WIN | Chip enables, one per window, active high |
| pb_a_hi | output | ADDR_W-16 | Upper address during the address phase |
| pb_a_lo | output | 3 | Low address pins, not shared with data |
| pb_ad_o | output | 16 | Shared address/data lines, driven value |
| pb_ad_oe | output | 1 | Drive enable for the shared lines |
| pb_ad_i | input | 16 | Shared lines, value read from the bus |
| pb_rd | output | 1 | Read strobe during data phases |
| pb_wr | output | 1 | Write strobe during data phases |
| pb_be | output | 2 | Byte lane enables during data phases |

## Verification
The main instance is built with `DATA_CYC`=3, so every transfer spans several clocks. This makes it possible to see that the low pins, the strobes and the write data stay steady across a whole transfer, and that read capture takes place only on its last clock. A second instance is built with `WRITE_SPLIT`=0, which gives the rejecting variant of long writes. The windows are placed so that one address lies exactly on window 0's upper edge and a later placement makes the two windows overlap. This exercises the strict upper limit and the priority of window 0.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_DATA  = 3'd2,
      ST_RECOV = 3'd3,
      ST_ERR   = 3'd4
   } pbus_state_e;

   localparam int unsigned PB_AD_W  = 16;
   localparam int unsigned PB_LO_W  = 3;
   localparam int unsigned PB_BEATS = 4;

   // Low address pins for a given start address and step count.
   function automatic logic [PB_LO_W-1:0] pb_low_pins(input logic bus16,
                                                     input logic [PB_LO_W-1:0] start,
                                                     input logic [1:0] step);
      logic [1:0] s;
      if (bus16) begin
         s = start[2:1] + step;
         return {s, 1'b0};
      end
      s = start[1:0] + step;
      return {start[2], s};
   endfunction

endpackage

// File: rtl/pbus_win_dec.sv
module pbus_win_dec #(
   parameter int unsigned ADDR_W  = 23,
   parameter int unsigned NUM_WIN = 2
) (
   input  logic [ADDR_W-1:0]         addr,
   input  logic [NUM_WIN*ADDR_W-1:0] win_base,
   input  logic [NUM_WIN*ADDR_W-1:0] win_size,
   output logic [NUM_WIN-1:0]        win_sel,
   output logic                      win_hit
);

   logic [NUM_WIN-1:0] raw_hit;

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
      logic [ADDR_W-1:0] base_k;
      logic [ADDR_W-1:0] size_k;
      logic [ADDR_W-1:0] offs_k;
      assign base_k     = win_base[k*ADDR_W +: ADDR_W];
      assign size_k     = win_size[k*ADDR_W +: ADDR_W];
      assign offs_k     = addr - base_k;
      assign raw_hit[k] = (addr >= base_k) && (offs_k < size_k);
   end

   // lowest index wins on overlap
   always_comb begin
      logic taken;
      taken   = 1'b0;
      win_sel = '0;
      for (int k = 0; k < NUM_WIN; k++) begin
         if (raw_hit[k] && !taken) begin
            win_sel[k] = 1'b1;
            taken      = 1'b1;
         end
      end
   end

   assign win_hit = |raw_hit;

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
   import pbus_pkg::*;
#(
   parameter int unsigned ADDR_W      = 23,
   parameter int unsigned DATA_CYC    = 2,
   parameter bit          WRITE_SPLIT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus16,
   input  logic                req_valid,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic                req_write,
   input  logic [1:0]          req_len,
   input  logic                win_hit,
   output logic                req_ready,
   output logic                accept,
   output pbus_state_e         state,
   output logic [ADDR_W-1:0]   xfer_addr,
   output logic                write_q,
   output logic [1:0]          beat_idx,
   output logic [1:0]          xfer_idx,
   output logic [PB_LO_W-1:0]  lo_pins,
   output logic                beat_end,
   output logic                rsp_valid,
   output logic                rsp_err
);

   localparam int unsigned     CYC_W    = (DATA_CYC > 1) ? $clog2(DATA_CYC) : 1;
   localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(DATA_CYC - 1);

   pbus_state_e        state_q, state_d;
   logic [ADDR_W-1:0]  addr_q;
   logic [1:0]         len_q;
   logic [1:0]         beat_q;
   logic [1:0]         xfer_q;
   logic [CYC_W-1:0]   cyc_q;
   logic               wr_q;
   logic               bad_req;
   logic               last_beat;
   logic               last_xfer;
   logic [ADDR_W-1:0]  step_bytes;

   if (WRITE_SPLIT) begin : g_split
      assign bad_req = !win_hit;
   end else begin : g_reject
      assign bad_req = !win_hit || (req_write && (req_len != 2'd0));
   end

   assign accept     = (state_q == ST_IDLE) && req_valid;
   assign beat_end   = (state_q == ST_DATA) && (cyc_q == CYC_LAST);
   assign last_beat  = wr_q || (beat_q == len_q);
   assign last_xfer  = !wr_q || (xfer_q == len_q);
   assign step_bytes = bus16 ? ADDR_W'(2) : ADDR_W'(1);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = bad_req ? ST_ERR : ST_ADDR;
         ST_ADDR:  state_d = ST_DATA;
         ST_DATA:  if (beat_end && last_beat) state_d = ST_RECOV;
         ST_RECOV: state_d = last_xfer ? ST_IDLE : ST_ADDR;
         ST_ERR:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         len_q   <= '0;
         beat_q  <= '0;
         xfer_q  <= '0;
         cyc_q   <= '0;
         wr_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  addr_q <= req_addr;
                  wr_q   <= req_write;
                  len_q  <= req_len;
                  beat_q <= '0;
                  xfer_q <= '0;
                  cyc_q  <= '0;
               end
            end
            ST_DATA: begin
               if (beat_end) begin
                  cyc_q <= '0;
                  if (!last_beat) beat_q <= beat_q + 2'd1;
               end else begin
                  cyc_q <= cyc_q + CYC_W'(1);
               end
            end
            ST_RECOV: begin
               if (!last_xfer) begin
                  xfer_q <= xfer_q + 2'd1;
                  beat_q <= '0;
                  addr_q <= addr_q + step_bytes;
               end
            end
            default: ;
         endcase
      end
   end

   assign state     = state_q;
   assign req_ready = (state_q == ST_IDLE);
   assign xfer_addr = addr_q;
   assign write_q   = wr_q;
   assign beat_idx  = beat_q;
   assign xfer_idx  = xfer_q;
   assign lo_pins   = pb_low_pins(bus16, addr_q[PB_LO_W-1:0], beat_q);
   assign rsp_valid = ((state_q == ST_RECOV) && last_xfer) || (state_q == ST_ERR);
   assign rsp_err   = (state_q == ST_ERR);

endmodule

// File: rtl/pbus_lane.sv
module pbus_lane
   import pbus_pkg::*;
#(
   parameter int unsigned BEATS = PB_BEATS,
   parameter int unsigned BUS_W = PB_AD_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus16,
   input  logic                    clear,
   input  logic                    capture,
   input  logic [1:0]              beat_idx,
   input  logic [1:0]              xfer_idx,
   input  logic [BEATS*BUS_W-1:0]  wdata,
   input  logic [BEATS*BUS_W/8-1:0] be,
   input  logic [BUS_W-1:0]        ad_in,
   output logic [BUS_W-1:0]        wr_data,
   output logic [BUS_W/8-1:0]      wr_be,
   output logic [BEATS*BUS_W-1:0]  rdata
);

   localparam int unsigned HALF_W = BUS_W / 2;

   logic [BUS_W-1:0]  wide_q   [BEATS];
   logic [HALF_W-1:0] narrow_q [BEATS];

   for (genvar g = 0; g < BEATS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wide_q[g]   <= '0;
            narrow_q[g] <= '0;
         end else if (clear) begin
            wide_q[g]   <= '0;
            narrow_q[g] <= '0;
         end else if (capture && (beat_idx == 2'(g))) begin
            wide_q[g]   <= ad_in;
            narrow_q[g] <= ad_in[HALF_W-1:0];
         end
      end
      always_comb begin
         rdata[g*BUS_W +: BUS_W] = '0;
         if (bus16) rdata[g*BUS_W +: BUS_W] = wide_q[g];
         else if (g < BEATS / 2)
            rdata[g*BUS_W +: BUS_W] = {narrow_q[2*g+1], narrow_q[2*g]};
      end
   end

   always_comb begin
      if (bus16) begin
         wr_data = wdata[xfer_idx*BUS_W +: BUS_W];
         wr_be   = be[xfer_idx*(BUS_W/8) +: (BUS_W/8)];
      end else begin
         wr_data = {{HALF_W{1'b0}}, wdata[xfer_idx*HALF_W +: HALF_W]};
         wr_be   = {{(BUS_W/8-1){1'b0}}, be[xfer_idx]};
      end
   end

endmodule

// File: rtl/pbus_mux_ctrl.sv
module pbus_mux_ctrl
   import pbus_pkg::*;
#(
   parameter int unsigned ADDR_W      = 23,
   parameter int unsigned NUM_WIN     = 2,
   parameter int unsigned DATA_CYC    = 2,
   parameter bit          WRITE_SPLIT = 1'b1,
   localparam int unsigned WORD_W     = PB_BEATS * PB_AD_W,
   localparam int unsigned BE_W       = WORD_W / 8,
   localparam int unsigned HI_W       = ADDR_W - PB_AD_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_bus16,
   input  logic [NUM_WIN*ADDR_W-1:0] cfg_win_base,
   input  logic [NUM_WIN*ADDR_W-1:0] cfg_win_size,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic                      req_write,
   input  logic [1:0]                req_len,
   input  logic [WORD_W-1:0]         req_wdata,
   input  logic [BE_W-1:0]           req_be,
   output logic                      rsp_valid,
   output logic                      rsp_err,
   output logic [WORD_W-1:0]         rsp_rdata,
   output logic                      pb_ale,
   output logic [NUM_WIN-1:0]        pb_ce,
   output logic [HI_W-1:0]           pb_a_hi,
   output logic [PB_LO_W-1:0]        pb_a_lo,
   output logic [PB_AD_W-1:0]        pb_ad_o,
   output logic                      pb_ad_oe,
   input  logic [PB_AD_W-1:0]        pb_ad_i,
   output logic                      pb_rd,
   output logic                      pb_wr,
   output logic [PB_AD_W/8-1:0]      pb_be
);

   if (ADDR_W <= PB_AD_W || HI_W > PB_AD_W) begin : g_bad_addr_w
      $error("pbus_mux_ctrl: ADDR_W must lie in 17..32");
   end
   if (DATA_CYC < 1) begin : g_bad_cyc
      $error("pbus_mux_ctrl: DATA_CYC must be at least 1");
   end
   if (NUM_WIN < 1) begin : g_bad_win
      $error("pbus_mux_ctrl: NUM_WIN must be at least 1");
   end

   pbus_state_e          state;
   logic                 accept;
   logic [ADDR_W-1:0]    xfer_addr;
   logic                 write_q;
   logic [1:0]           beat_idx;
   logic [1:0]           xfer_idx;
   logic [PB_LO_W-1:0]   lo_pins;
   logic                 beat_end;
   logic [NUM_WIN-1:0]   win_sel;
   logic                 win_hit;
   logic [NUM_WIN-1:0]   sel_q;
   logic [PB_AD_W-1:0]   wr_data;
   logic [PB_AD_W/8-1:0] wr_be;
   logic                 in_addr;
   logic                 in_data;
   logic                 busy;

   pbus_win_dec #(
      .ADDR_W  (ADDR_W),
      .NUM_WIN (NUM_WIN)
   ) u_dec (
      .addr     (req_addr),
      .win_base (cfg_win_base),
      .win_size (cfg_win_size),
      .win_sel  (win_sel),
      .win_hit  (win_hit)
   );

   pbus_seq #(
      .ADDR_W      (ADDR_W),
      .DATA_CYC    (DATA_CYC),
      .WRITE_SPLIT (WRITE_SPLIT)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus16     (cfg_bus16),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_write (req_write),
      .req_len   (req_len),
      .win_hit   (win_hit),
      .req_ready (req_ready),
      .accept    (accept),
      .state     (state),
      .xfer_addr (xfer_addr),
      .write_q   (write_q),
      .beat_idx  (beat_idx),
      .xfer_idx  (xfer_idx),
      .lo_pins   (lo_pins),
      .beat_end  (beat_end),
      .rsp_valid (rsp_valid),
      .rsp_err   (rsp_err)
   );

   pbus_lane #(
      .BEATS (PB_BEATS),
      .BUS_W (PB_AD_W)
   ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus16    (cfg_bus16),
      .clear    (accept),
      .capture  (beat_end && !write_q),
      .beat_idx (beat_idx),
      .xfer_idx (xfer_idx),
      .wdata    (req_wdata),
      .be       (req_be),
      .ad_in    (pb_ad_i),
      .wr_data  (wr_data),
      .wr_be    (wr_be),
      .rdata    (rsp_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (accept) sel_q <= win_sel;
   end

   assign in_addr = (state == ST_ADDR);
   assign in_data = (state == ST_DATA);
   assign busy    = in_addr || in_data || (state == ST_RECOV);

   assign pb_ale   = in_addr;
   assign pb_ce    = (in_addr || in_data) ? sel_q : '0;
   assign pb_a_hi  = in_addr ? xfer_addr[ADDR_W-1:PB_AD_W] : '0;
   assign pb_a_lo  = busy ? lo_pins : '0;
   assign pb_rd    = in_data && !write_q;
   assign pb_wr    = in_data && write_q;
   assign pb_ad_oe = in_addr || (in_data && write_q);

   always_comb begin
      pb_ad_o = '0;
      pb_be   = '0;
      if (in_addr) begin
         pb_ad_o = xfer_addr[PB_AD_W-1:0];
      end else if (in_data) begin
         if (write_q) begin
            pb_ad_o = wr_data;
            pb_be   = wr_be;
         end else begin
            pb_be = cfg_bus16 ? '1 : (PB_AD_W/8)'(1);
         end
      end
   end

endmodule

// File: rtl/pbus_mux_ctrl_chk.sv
module pbus_mux_ctrl_chk #(
   parameter int unsigned NUM_WIN = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_bus16,
   input logic               req_ready,
   input logic               rsp_valid,
   input logic               rsp_err,
   input logic               pb_ale,
   input logic [NUM_WIN-1:0] pb_ce,
   input logic [2:0]         pb_a_lo,
   input logic               pb_ad_oe,
   input logic               pb_rd,
   input logic               pb_wr
);

   // R2
   ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pb_ale |=> !pb_ale);

   // R2
   ale_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pb_ale |-> (pb_ce != '0) && !pb_rd && !pb_wr);

   // R8
   ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pb_ce));

   // R3
   rd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pb_rd |-> !pb_ad_oe);

   // R11
   recov_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pb_ale |-> ($past(pb_ce) == '0) && !$past(pb_rd) && !$past(pb_wr));

   // R9
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (pb_ce == '0) && !pb_ale);

   // R12
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || pb_ale || pb_rd || pb_wr) |-> !req_ready);

   // R10
   wr_lo_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_wr && $past(pb_wr)) |-> $stable(pb_a_lo));

   // R6
   byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bus16 && pb_rd && $past(pb_rd) && (pb_a_lo != $past(pb_a_lo)))
      |-> (pb_a_lo[1:0] == $past(pb_a_lo[1:0]) + 2'd1) && (pb_a_lo[2] == $past(pb_a_lo[2])));

   // R5
   half_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bus16 && pb_rd && $past(pb_rd) && (pb_a_lo != $past(pb_a_lo)))
      |-> (pb_a_lo[2:1] == $past(pb_a_lo[2:1]) + 2'd1) && !pb_a_lo[0]);

endmodule

bind pbus_mux_ctrl pbus_mux_ctrl_chk #(
   .NUM_WIN (NUM_WIN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_bus16 (cfg_bus16),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .pb_ale    (pb_ale),
   .pb_ce     (pb_ce),
   .pb_a_lo   (pb_a_lo),
   .pb_ad_oe  (pb_ad_oe),
   .pb_rd     (pb_rd),
   .pb_wr     (pb_wr)
);

// File: tb/pbus_mux_ctrl_bench.sv
module pbus_mux_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 23;
   localparam int NW = 2;
   localparam int DC = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_bus16 = 1'b1;
   logic [AW-1:0] win_base [NW];
   logic [AW-1:0] win_size [NW];
   logic [NW*AW-1:0] cfg_win_base;
   logic [NW*AW-1:0] cfg_win_size;
   logic          req_valid = 1'b0;
   logic          req_valid_ns = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0;
   logic [1:0]    req_len = '0;
   logic [63:0]   req_wdata = '0;
   logic [7:0]    req_be = '0;

   logic          req_ready, rsp_valid, rsp_err;
   logic [63:0]   rsp_rdata;
   logic          pb_ale, pb_ad_oe, pb_rd, pb_wr;
   logic [NW-1:0] pb_ce;
   logic [6:0]    pb_a_hi;
   logic [2:0]    pb_a_lo;
   logic [15:0]   pb_ad_o, pb_ad_i;
   logic [1:0]    pb_be;

   logic          ns_ready, ns_rsp_valid, ns_rsp_err, ns_ale, ns_oe, ns_rd, ns_wr;
   logic [63:0]   ns_rdata;
   logic [NW-1:0] ns_ce;
   logic [6:0]    ns_a_hi;
   logic [2:0]    ns_a_lo;
   logic [15:0]   ns_ad_o;
   logic [1:0]    ns_be;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign cfg_win_base = {win_base[1], win_base[0]};
   assign cfg_win_size = {win_size[1], win_size[0]};

   pbus_mux_ctrl #(.ADDR_W(AW), .NUM_WIN(NW), .DATA_CYC(DC), .WRITE_SPLIT(1'b1)) u_pbus_mux_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_bus16(cfg_bus16),
      .cfg_win_base(cfg_win_base), .cfg_win_size(cfg_win_size),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_len(req_len), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .pb_ale(pb_ale), .pb_ce(pb_ce), .pb_a_hi(pb_a_hi), .pb_a_lo(pb_a_lo),
      .pb_ad_o(pb_ad_o), .pb_ad_oe(pb_ad_oe), .pb_ad_i(pb_ad_i),
      .pb_rd(pb_rd), .pb_wr(pb_wr), .pb_be(pb_be));

   pbus_mux_ctrl #(.ADDR_W(AW), .NUM_WIN(NW), .DATA_CYC(DC), .WRITE_SPLIT(1'b0)) u_pbus_mux_ctrl_nosplit (
      .clk(clk), .rst_n(rst_n), .cfg_bus16(cfg_bus16),
      .cfg_win_base(cfg_win_base), .cfg_win_size(cfg_win_size),
      .req_valid(req_valid_ns), .req_ready(ns_ready), .req_addr(req_addr),
      .req_write(req_write), .req_len(req_len), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(ns_rsp_valid), .rsp_err(ns_rsp_err), .rsp_rdata(ns_rdata),
      .pb_ale(ns_ale), .pb_ce(ns_ce), .pb_a_hi(ns_a_hi), .pb_a_lo(ns_a_lo),
      .pb_ad_o(ns_ad_o), .pb_ad_oe(ns_oe), .pb_ad_i(16'h0000),
      .pb_rd(ns_rd), .pb_wr(ns_wr), .pb_be(ns_be));

   // external device model: latch the address on the strobe, answer from a pattern
   logic [AW-1:0] dev_lat = '0;
   logic [AW-1:0] dev_addr;
   always @(posedge clk) if (pb_ale) dev_lat <= {pb_a_hi, pb_ad_o};
   assign dev_addr = {dev_lat[AW-1:3], pb_a_lo};

   function automatic logic [15:0] pat16(input logic [AW-1:0] a);
      return a[15:0] ^ 16'hC3A5 ^ {a[22:16], 9'h000};
   endfunction

   function automatic logic [7:0] pat8(input logic [AW-1:0] a);
      logic [15:0] t;
      t = pat16(a);
      return t[7:0] ^ t[15:8];
   endfunction

   assign pb_ad_i = cfg_bus16 ? pat16(dev_addr) : {8'h00, pat8(dev_addr)};

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_lo(input logic [AW-1:0] a, input int b);
      logic [1:0] s;
      if (cfg_bus16) begin
         s = a[2:1] + 2'(b);
         return {s, 1'b0};
      end
      s = a[1:0] + 2'(b);
      return {a[2], s};
   endfunction

   // Runs one request on the main instance and checks the bus cycle by cycle.
   task automatic run_access(input logic [AW-1:0] addr, input logic wr, input logic [1:0] len,
                             input logic [63:0] wdata, input logic [7:0] be,
                             input logic [NW-1:0] exp_ce, output logic [63:0] rdata_o);
      int nb, ntx, tlen, last_c;
      logic [AW-1:0] step;
      nb   = wr ? 1 : int'(len) + 1;
      ntx  = wr ? int'(len) + 1 : 1;
      tlen = 2 + nb * DC;
      last_c = (exp_ce == '0) ? 1 : ntx * tlen;
      step = cfg_bus16 ? AW'(2) : AW'(1);
      rdata_o = '0;
      @(negedge clk);
      check(req_ready == 1'b1, "R12 ready before request", 64'(req_ready), 64'd1);
      req_addr = addr; req_write = wr; req_len = len; req_wdata = wdata; req_be = be;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int c = 1; c <= last_c; c++) begin
         if (c > 1) @(negedge clk);
         check(req_ready == 1'b0, "R12 ready low while busy", 64'(req_ready), 64'd0);
         if (exp_ce == '0) begin
            check(rsp_valid && rsp_err, "R9 error response", {62'd0, rsp_valid, rsp_err}, 64'd3);
            check(!pb_ale && pb_ce == '0, "R9 no bus activity", {61'd0, pb_ale, pb_ce}, 64'd0);
         end else begin
            int x, p, b;
            logic [AW-1:0] xa;
            x  = (c - 1) / tlen;
            p  = (c - 1) % tlen;
            xa = addr + AW'(x) * step;
            if (p == 0) begin
               check(pb_ale == 1'b1, "R2 strobe in address phase", 64'(pb_ale), 64'd1);
               check({pb_a_hi, pb_ad_o} == xa && pb_ad_oe, "R2 address on bus",
                     64'({pb_a_hi, pb_ad_o}), 64'(xa));
               check(pb_ce == exp_ce, "R8 chip enable in address phase", 64'(pb_ce), 64'(exp_ce));
               check(!rsp_valid, "R11 no early response", 64'(rsp_valid), 64'd0);
            end else if (p < tlen - 1) begin
               b = wr ? 0 : (p - 1) / DC;
               check(!pb_ale, "R2 strobe only one clock", 64'(pb_ale), 64'd0);
               check(pb_rd == !wr && pb_wr == wr, "R4 strobe in data phase",
                     {62'd0, pb_rd, pb_wr}, {62'd0, !wr, wr});
               check(pb_ce == exp_ce, "R8 chip enable in data phase", 64'(pb_ce), 64'(exp_ce));
               check(pb_a_lo == exp_lo(xa, b), wr ? "R10 low pins on write" : (cfg_bus16 ? "R5 low pins" : "R6 low pins"),
                     64'(pb_a_lo), 64'(exp_lo(xa, b)));
               if (wr) begin
                  logic [15:0] ed;
                  logic [1:0]  eb;
                  ed = cfg_bus16 ? wdata[16*x +: 16] : {8'h00, wdata[8*x +: 8]};
                  eb = cfg_bus16 ? be[2*x +: 2] : {1'b0, be[x]};
                  check(pb_ad_oe && pb_ad_o == ed, "R10 write lane data", 64'(pb_ad_o), 64'(ed));
                  check(pb_be == eb, "R10 write lane enables", 64'(pb_be), 64'(eb));
               end else begin
                  check(!pb_ad_oe, "R3 lines released on read", 64'(pb_ad_oe), 64'd0);
               end
            end else begin
               check(pb_ce == '0 && !pb_rd && !pb_wr && !pb_ale, "R11 recovery clock",
                     {60'd0, pb_ce, pb_rd, pb_wr}, 64'd0);
               check(rsp_valid == (x == ntx - 1), "R11 response in final recovery",
                     64'(rsp_valid), 64'(x == ntx - 1));
               if (x == ntx - 1) begin
                  check(!rsp_err, "R11 no error on good access", 64'(rsp_err), 64'd0);
                  rdata_o = rsp_rdata;
               end
            end
         end
      end
      @(negedge clk);
      check(req_ready && !rsp_valid, "R12 ready after response", {62'd0, req_ready, rsp_valid}, 64'd2);
   endtask

   function automatic logic [63:0] exp_read(input logic [AW-1:0] a, input int len);
      logic [63:0] r;
      logic [1:0]  s;
      r = '0;
      for (int b = 0; b <= len; b++) begin
         if (cfg_bus16) begin
            s = a[2:1] + 2'(b);
            r[16*b +: 16] = pat16({a[AW-1:3], s, 1'b0});
         end else begin
            s = a[1:0] + 2'(b);
            r[8*b +: 8] = pat8({a[AW-1:2], s});
         end
      end
      return r;
   endfunction

   task automatic t_reset();
      check(req_ready && !pb_ale && pb_ce == '0 && !pb_rd && !pb_wr && !rsp_valid,
            "R1 idle after reset", {58'd0, req_ready, pb_ale, pb_ce, pb_rd, pb_wr}, 64'h20);
   endtask

   task automatic t_single_read16();
      logic [63:0] rd;
      cfg_bus16 = 1'b1;
      run_access(23'h01_2346, 1'b0, 2'd0, '0, '0, 2'b01, rd);
      check(rd == exp_read(23'h01_2346, 0), "R7 single read data", rd, exp_read(23'h01_2346, 0));
   endtask

   task automatic t_burst_read16();
      logic [63:0] rd;
      cfg_bus16 = 1'b1;
      run_access(23'h01_5A34, 1'b0, 2'd3, '0, '0, 2'b01, rd);
      check(rd == exp_read(23'h01_5A34, 3), "R5 wrapped burst assembly", rd, exp_read(23'h01_5A34, 3));
   endtask

   task automatic t_burst_read8();
      logic [63:0] rd;
      cfg_bus16 = 1'b0;
      run_access(23'h40_0C05, 1'b0, 2'd3, '0, '0, 2'b10, rd);
      check(rd == exp_read(23'h40_0C05, 3), "R6 byte burst assembly", rd, exp_read(23'h40_0C05, 3));
      run_access(23'h40_0C07, 1'b0, 2'd1, '0, '0, 2'b10, rd);
      check(rd == exp_read(23'h40_0C07, 1), "R6 short byte burst", rd, exp_read(23'h40_0C07, 1));
      cfg_bus16 = 1'b1;
   endtask

   task automatic t_windows();
      logic [63:0] rd;
      cfg_bus16 = 1'b1;
      run_access(23'h01_FFFE, 1'b0, 2'd0, '0, '0, 2'b01, rd);
      check(rd == exp_read(23'h01_FFFE, 0), "R8 top of window 0", rd, exp_read(23'h01_FFFE, 0));
      run_access(23'h02_0000, 1'b0, 2'd0, '0, '0, 2'b00, rd);
      win_base[1] = 23'h01_8000;
      run_access(23'h01_8000, 1'b0, 2'd0, '0, '0, 2'b01, rd);
      run_access(23'h02_0000, 1'b0, 2'd0, '0, '0, 2'b10, rd);
      check(rd == exp_read(23'h02_0000, 0), "R8 window 1 read", rd, exp_read(23'h02_0000, 0));
      win_base[1] = 23'h40_0000;
   endtask

   task automatic t_error();
      logic [63:0] rd;
      run_access(23'h00_0010, 1'b0, 2'd2, '0, '0, 2'b00, rd);
      run_access(23'h60_0000, 1'b1, 2'd0, 64'h1234, 8'h03, 2'b00, rd);
   endtask

   task automatic t_writes();
      logic [63:0] rd;
      cfg_bus16 = 1'b1;
      run_access(23'h01_0102, 1'b1, 2'd2, 64'h0000_7777_BEEF_CAFE, 8'b0010_1101, 2'b01, rd);
      check(rd == 64'd0, "R10 write leaves read data empty", rd, 64'd0);
      cfg_bus16 = 1'b0;
      run_access(23'h40_0011, 1'b1, 2'd3, 64'h0000_0000_A1B2_C3D4, 8'b0000_1010, 2'b10, rd);
      run_access(23'h40_0020, 1'b1, 2'd0, 64'h0000_0000_0000_005E, 8'b0000_0001, 2'b10, rd);
      cfg_bus16 = 1'b1;
   endtask

   task automatic t_nosplit();
      @(negedge clk);
      req_addr = 23'h01_0200; req_write = 1'b1; req_len = 2'd1;
      req_wdata = 64'h1111_2222; req_be = 8'h0F;
      check(ns_ready == 1'b1, "R10 reject variant idle", 64'(ns_ready), 64'd1);
      req_valid_ns = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid_ns = 1'b0;
      check(ns_rsp_valid && ns_rsp_err, "R10 long write rejected", {62'd0, ns_rsp_valid, ns_rsp_err}, 64'd3);
      check(!ns_ale && ns_ce == '0 && !ns_wr, "R10 rejected write quiet", {60'd0, ns_ale, ns_ce, ns_wr}, 64'd0);
      @(negedge clk);
      check(ns_ready && !ns_rsp_valid, "R12 reject variant ready again", {62'd0, ns_ready, ns_rsp_valid}, 64'd2);
   endtask

   initial begin
      win_base[0] = 23'h01_0000; win_size[0] = 23'h01_0000;
      win_base[1] = 23'h40_0000; win_size[1] = 23'h10_0000;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_read16();
      t_burst_read16();
      t_burst_read8();
      t_windows();
      t_error();
      t_writes();
      t_nosplit();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      bad++;
      total++;
      $display("FAIL watchdog expired act=%0d exp=0", total);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule